// File: doc/BRIEF.md
# SCSI DMA Transfer Counter

This block moves bytes between a SCSI target, modelled as a byte stream with a valid/ready handshake, and a local buffer RAM kept inside the block. The buffer is a power-of-two window of `2^WIN_AW` bytes. The product setting is `WIN_AW = 17`, which gives 128 KiB. The default elaborates a 2 KiB window so that the array stays small. The host loads a byte count, split over three byte registers, and a 32-bit DMA address, written as four separate bytes. It then issues a command. Only a command that carries the DMA qualifier bit starts a transfer.

Once started, the block walks through the buffer one byte per handshake. Buffer offsets are taken modulo the window. Inbound transfers are clipped at the end of the window; outbound transfers wrap around it. The readable count follows the bytes that remain. A terminal-count flag marks a transfer that ran its full length. If the target ends the inbound stream early, the block stops with a nonzero residual count and does not set the flag.

Top module: `sdma_xfer_ctl`

## Requirements
- R1: After reset, `busy`, `tc_flag`, `xfer_cnt` and `dma_addr` are all zero, and neither `in_ready` nor `out_valid` is asserted.
- R2: A host write with `reg_sel` = 4, 5, 6 or 7 sets `dma_addr` bits [7:0], [15:8], [23:16] or [31:24] in that order. `reg_sel` = 0, 1 and 2 load the low, middle and high count bytes.
- R3: The transfer length is low + 256 × middle. A length of zero stands for 65536 bytes.
- R4: A command with `cmd_valid` and `cmd_dma` high while the block is idle starts a transfer. On the next cycle `busy` is 1, `tc_flag` is 0, and `xfer_cnt` equals {high, middle, low} as written.
- R5: When the last byte of the length moves, the block drops `busy`, sets `tc_flag`, and shows `xfer_cnt` = 0. `tc_flag` is never set while bytes remain.
- R6: Each byte moved lowers `xfer_cnt` to the number of bytes still to move. A cycle with no handshake leaves it unchanged.
- R7: If an inbound byte accepted with `in_last` = 1 is not the final byte of the length, the block goes idle with `tc_flag` = 0 and `xfer_cnt` = bytes still outstanding.
- R8: Byte i of a transfer uses buffer offset (dma_addr + i) mod 2^WIN_AW. Address bits above the window have no effect, and outbound transfers wrap from the top of the window to offset 0.
- R9: An inbound length is clipped to 2^WIN_AW − offset, so an inbound transfer never wraps. A clipped transfer still ends with `tc_flag` = 1 and `xfer_cnt` = 0.
- R10: A command with `cmd_dma` = 0 changes nothing: `busy`, `tc_flag` and `xfer_cnt` keep their values.
- R11: A DMA command issued while `busy` is 1 is ignored. The running count is not reloaded.
- R12: `in_ready` is high only during an inbound transfer, with `cmd_dir_in` = 1 at start. `out_valid` is high only during an outbound transfer, with `cmd_dir_in` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_we | input | 1 | Host register write strobe |
| reg_sel | input | 3 | Register select: 0..2 count bytes, 4..7 address bytes |
| reg_wdata | input | 8 | Host write byte |
| cmd_valid | input | 1 | Command strobe |
| cmd_dma | input | 1 | DMA qualifier bit of the command |
| cmd_dir_in | input | 1 | 1 = target to buffer, 0 = buffer to target |
| in_valid | input | 1 | Inbound byte valid |
| in_data | input | DATA_W | Inbound byte |
| in_last | input | 1 | Target ends the inbound stream with this byte |
| in_ready | output | 1 | Block accepts an inbound byte |
| out_valid | output | 1 | Outbound byte valid |
| out_data | output | DATA_W | Outbound byte read from the buffer |
| out_ready | input | 1 | Target takes the outbound byte |
| dma_addr | output | ADDR_W | Assembled DMA address |
| xfer_cnt | output | 24 | Readable transfer count |
| tc_flag | output | 1 | Terminal count reached |
| busy | output | 1 | Transfer in progress |

## Verification
The bench aims at the count encoding and the window edges. Programming zero must move 65536 outbound bytes; a design that treats zero literally would stop at once or after 0 bytes. An inbound transfer that starts 3 bytes below the top of the window must take exactly 3 bytes and still set terminal count; a design without clipping would wrap and overwrite offset 0. An outbound read that crosses the top of the window must return the bytes stored at offset 0 onward, while address bits above the window are set. Further checks cover an early stream end, which must leave a residual count and no terminal count; a DMA command sent mid-transfer, which must not reload the count; and a command without the DMA bit, which must not clear a standing terminal count.

// File: rtl/sdma_pkg.sv
package sdma_pkg;

   localparam int SDMA_BYTE_W = 8;
   localparam int SDMA_SEL_W  = 3;

   // Host register selector encoding (address bytes start at ADR0).
   typedef enum logic [SDMA_SEL_W-1:0] {
      SEL_CNT_LO  = 3'd0,
      SEL_CNT_MID = 3'd1,
      SEL_CNT_HI  = 3'd2,
      SEL_SPARE   = 3'd3,
      SEL_ADR0    = 3'd4,
      SEL_ADR1    = 3'd5,
      SEL_ADR2    = 3'd6,
      SEL_ADR3    = 3'd7
   } sdma_sel_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_IN   = 2'd1,
      ST_OUT  = 2'd2
   } sdma_st_e;

endpackage

// File: rtl/sdma_hreg.sv
// Host-written side of the count and address registers.
module sdma_hreg
   import sdma_pkg::*;
#(
   parameter int ADDR_W = 32
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   we,
   input  logic [SDMA_SEL_W-1:0]  sel,
   input  logic [SDMA_BYTE_W-1:0] wdata,
   output logic [SDMA_BYTE_W-1:0] cnt_lo,
   output logic [SDMA_BYTE_W-1:0] cnt_mid,
   output logic [SDMA_BYTE_W-1:0] cnt_hi,
   output logic [ADDR_W-1:0]      addr
);
   localparam int NB = ADDR_W / SDMA_BYTE_W;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_lo  <= '0;
         cnt_mid <= '0;
         cnt_hi  <= '0;
      end else if (we) begin
         case (sel)
            SEL_CNT_LO:  cnt_lo  <= wdata;
            SEL_CNT_MID: cnt_mid <= wdata;
            SEL_CNT_HI:  cnt_hi  <= wdata;
            default: ;
         endcase
      end
   end

   // One byte lane per address byte, little-endian by selector order.
   for (genvar b = 0; b < NB; b++) begin : g_abyte
      logic [SDMA_BYTE_W-1:0] byte_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            byte_q <= '0;
         else if (we && sel == SDMA_SEL_W'(int'(SEL_ADR0) + b))
            byte_q <= wdata;
      end
      assign addr[b*SDMA_BYTE_W +: SDMA_BYTE_W] = byte_q;
   end

endmodule

// File: rtl/sdma_len_calc.sv
// Effective byte length: zero means the full 16-bit span, inbound clipped at window top.
module sdma_len_calc
   import sdma_pkg::*;
#(
   parameter int WIN_AW       = 11,
   parameter int CW           = 17,
   parameter bit CLIP_INBOUND = 1'b1
) (
   input  logic [SDMA_BYTE_W-1:0] cnt_lo,
   input  logic [SDMA_BYTE_W-1:0] cnt_mid,
   input  logic [WIN_AW-1:0]      offset,
   input  logic                   dir_in,
   output logic [CW-1:0]          len_eff
);
   localparam int PROG_W = 2 * SDMA_BYTE_W;

   logic [PROG_W-1:0] prog;
   logic [CW-1:0]     raw;
   logic [CW-1:0]     room;

   assign prog = {cnt_mid, cnt_lo};
   assign raw  = (prog == '0) ? CW'(2 ** PROG_W) : CW'(prog);
   assign room = CW'(2 ** WIN_AW) - CW'(offset);

   if (CLIP_INBOUND) begin : g_clip
      assign len_eff = (dir_in && (raw > room)) ? room : raw;
   end else begin : g_noclip
      assign len_eff = raw;
   end

endmodule

// File: rtl/sdma_buf.sv
// Local buffer: one write port, one asynchronous read port.
module sdma_buf #(
   parameter int WIN_AW = 11,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              wr_en,
   input  logic [WIN_AW-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [WIN_AW-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data
);
   localparam int DEPTH = 2 ** WIN_AW;

   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en)
         mem[wr_addr] <= wr_data;
   end

   assign rd_data = mem[rd_addr];

endmodule

// File: rtl/sdma_xfer_ctl.sv
module sdma_xfer_ctl
   import sdma_pkg::*;
#(
   parameter int WIN_AW       = 11,
   parameter int DATA_W       = 8,
   parameter int ADDR_W       = 32,
   parameter bit CLIP_INBOUND = 1'b1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   reg_we,
   input  logic [2:0]             reg_sel,
   input  logic [7:0]             reg_wdata,
   input  logic                   cmd_valid,
   input  logic                   cmd_dma,
   input  logic                   cmd_dir_in,
   input  logic                   in_valid,
   input  logic [DATA_W-1:0]      in_data,
   input  logic                   in_last,
   output logic                   in_ready,
   output logic                   out_valid,
   output logic [DATA_W-1:0]      out_data,
   input  logic                   out_ready,
   output logic [ADDR_W-1:0]      dma_addr,
   output logic [23:0]            xfer_cnt,
   output logic                   tc_flag,
   output logic                   busy
);
   localparam int CNT_W  = 3 * SDMA_BYTE_W;
   localparam int LEN_W  = 2 * SDMA_BYTE_W + 1;
   localparam int CW     = (LEN_W > WIN_AW + 1) ? LEN_W : WIN_AW + 1;

   if (WIN_AW < 4 || WIN_AW > 17) begin : g_bad_win
      $error("sdma_xfer_ctl: WIN_AW must lie in 4..17");
   end
   if ((ADDR_W % SDMA_BYTE_W) != 0 || ADDR_W > 32 || ADDR_W < WIN_AW) begin : g_bad_addr
      $error("sdma_xfer_ctl: ADDR_W must be whole bytes, at most 32, covering the window");
   end
   if (DATA_W != SDMA_BYTE_W) begin : g_bad_data
      $error("sdma_xfer_ctl: DATA_W must be one byte");
   end

   logic [SDMA_BYTE_W-1:0] cnt_lo, cnt_mid, cnt_hi;
   logic [CW-1:0]          len_eff;

   sdma_st_e               st_q;
   logic [CW-1:0]          remain;
   logic [WIN_AW-1:0]      ptr_q;
   logic [CNT_W-1:0]       cnt_q;
   logic                   tc_q;

   logic start, beat, last_beat, mem_we;

   sdma_hreg #(.ADDR_W(ADDR_W)) u_hreg (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (reg_we),
      .sel     (reg_sel),
      .wdata   (reg_wdata),
      .cnt_lo  (cnt_lo),
      .cnt_mid (cnt_mid),
      .cnt_hi  (cnt_hi),
      .addr    (dma_addr)
   );

   sdma_len_calc #(.WIN_AW(WIN_AW), .CW(CW), .CLIP_INBOUND(CLIP_INBOUND)) u_len (
      .cnt_lo  (cnt_lo),
      .cnt_mid (cnt_mid),
      .offset  (dma_addr[WIN_AW-1:0]),
      .dir_in  (cmd_dir_in),
      .len_eff (len_eff)
   );

   sdma_buf #(.WIN_AW(WIN_AW), .DATA_W(DATA_W)) u_buf (
      .clk     (clk),
      .wr_en   (mem_we),
      .wr_addr (ptr_q),
      .wr_data (in_data),
      .rd_addr (ptr_q),
      .rd_data (out_data)
   );

   assign in_ready  = (st_q == ST_IN);
   assign out_valid = (st_q == ST_OUT);
   assign busy      = (st_q != ST_IDLE);
   assign start     = cmd_valid && cmd_dma && (st_q == ST_IDLE);
   assign mem_we    = in_ready && in_valid;
   assign beat      = mem_we || (out_valid && out_ready);
   assign last_beat = (remain == CW'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         remain <= '0;
         ptr_q  <= '0;
         cnt_q  <= '0;
         tc_q   <= 1'b0;
      end else if (start) begin
         st_q   <= cmd_dir_in ? ST_IN : ST_OUT;
         remain <= len_eff;
         ptr_q  <= dma_addr[WIN_AW-1:0];
         cnt_q  <= {cnt_hi, cnt_mid, cnt_lo};
         tc_q   <= 1'b0;
      end else if (beat) begin
         remain <= remain - CW'(1);
         ptr_q  <= ptr_q + WIN_AW'(1);
         cnt_q  <= CNT_W'(remain - CW'(1));
         if (last_beat) begin
            st_q <= ST_IDLE;
            tc_q <= 1'b1;
         end else if (in_ready && in_last) begin
            st_q <= ST_IDLE;
         end
      end
   end

   assign xfer_cnt = cnt_q;
   assign tc_flag  = tc_q;

endmodule

// File: rtl/sdma_xfer_chk.sv
module sdma_xfer_chk #(
   parameter int CW = 17
) (
   input logic          clk,
   input logic          rst_n,
   input logic          start,
   input logic          beat,
   input logic          busy,
   input logic          tc_flag,
   input logic [23:0]   xfer_cnt,
   input logic [CW-1:0] remain,
   input logic          in_ready,
   input logic          out_valid,
   input logic          cmd_valid,
   input logic          cmd_dma
);
   a_r4_start_clears_tc: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (busy && !tc_flag));

   a_r5_tc_means_zero: assert property (@(posedge clk) disable iff (!rst_n)
      tc_flag |-> (xfer_cnt == 24'd0 && !busy));

   a_r6_one_per_byte: assert property (@(posedge clk) disable iff (!rst_n)
      (beat && !start) |=> (remain == $past(remain) - CW'(1)));

   a_r7_residual_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(busy) && !tc_flag) |-> (xfer_cnt != 24'd0));

   a_r10_nondma_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && cmd_valid && !cmd_dma) |=> (!busy && $stable(xfer_cnt) && $stable(tc_flag)));

   a_r11_no_reload: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && cmd_valid && cmd_dma && !beat) |=> $stable(xfer_cnt));

   a_r12_one_direction: assert property (@(posedge clk) disable iff (!rst_n)
      !(in_ready && out_valid));

endmodule

bind sdma_xfer_ctl sdma_xfer_chk #(.CW(CW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .start     (start),
   .beat      (beat),
   .busy      (busy),
   .tc_flag   (tc_flag),
   .xfer_cnt  (xfer_cnt),
   .remain    (remain),
   .in_ready  (in_ready),
   .out_valid (out_valid),
   .cmd_valid (cmd_valid),
   .cmd_dma   (cmd_dma)
);

// File: tb/sdma_xfer_ctl_tb.sv
module sdma_xfer_ctl_tb;
   localparam int WIN = 2048;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [2:0]  reg_sel = '0;
   logic [7:0]  reg_wdata = '0;
   logic        cmd_valid = 1'b0, cmd_dma = 1'b0, cmd_dir_in = 1'b0;
   logic        in_valid = 1'b0, in_last = 1'b0;
   logic [7:0]  in_data = '0;
   logic        in_ready, out_valid, out_ready = 1'b0;
   logic [7:0]  out_data;
   logic [31:0] dma_addr;
   logic [23:0] xfer_cnt;
   logic        tc_flag, busy;

   int n_chk = 0;
   int n_bad = 0;

   always #5 clk = ~clk;

   sdma_xfer_ctl u_dut (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
      .cmd_valid(cmd_valid), .cmd_dma(cmd_dma), .cmd_dir_in(cmd_dir_in),
      .in_valid(in_valid), .in_data(in_data), .in_last(in_last), .in_ready(in_ready),
      .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready),
      .dma_addr(dma_addr), .xfer_cnt(xfer_cnt), .tc_flag(tc_flag), .busy(busy)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic summary();
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      repeat (180000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      summary();
   end

   task automatic wr_reg(input logic [2:0] s, input logic [7:0] v);
      reg_we = 1'b1; reg_sel = s; reg_wdata = v;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic set_addr(input logic [31:0] a);
      wr_reg(3'd4, a[7:0]);
      wr_reg(3'd5, a[15:8]);
      wr_reg(3'd6, a[23:16]);
      wr_reg(3'd7, a[31:24]);
   endtask

   task automatic set_cnt(input logic [7:0] lo, input logic [7:0] mid, input logic [7:0] hi);
      wr_reg(3'd0, lo);
      wr_reg(3'd1, mid);
      wr_reg(3'd2, hi);
   endtask

   task automatic issue(input logic dma, input logic dir);
      cmd_valid = 1'b1; cmd_dma = dma; cmd_dir_in = dir;
      @(negedge clk);
      cmd_valid = 1'b0; cmd_dma = 1'b0;
   endtask

   task automatic push(input logic [7:0] d, input logic last);
      in_valid = 1'b1; in_data = d; in_last = last;
      @(negedge clk);
      in_valid = 1'b0; in_last = 1'b0;
   endtask

   task automatic pull(input string tag, input logic [7:0] exp);
      chk({tag, " out_valid"}, 32'(out_valid), 32'd1);
      chk({tag, " out_data"}, 32'(out_data), 32'(exp));
      out_ready = 1'b1;
      @(negedge clk);
      out_ready = 1'b0;
   endtask

   task automatic t_reset();
      chk("R1 busy", 32'(busy), 0);
      chk("R1 tc", 32'(tc_flag), 0);
      chk("R1 cnt", 32'(xfer_cnt), 0);
      chk("R1 addr", dma_addr, 0);
      chk("R1 handshakes", 32'({in_ready, out_valid}), 0);
   endtask

   task automatic t_addr();
      set_addr(32'h1234_5678);
      chk("R2 address assembly", dma_addr, 32'h1234_5678);
   endtask

   // Inbound 5 bytes to offset 0x10 with stall cycles.
   task automatic t_inbound();
      set_addr(32'h0000_0010);
      set_cnt(8'd5, 8'd0, 8'hA5);
      issue(1'b1, 1'b1);
      chk("R4 copy count", 32'(xfer_cnt), 32'hA5_0005);
      chk("R4 busy", 32'(busy), 1);
      chk("R12 in_ready", 32'(in_ready), 1);
      chk("R12 out_valid low", 32'(out_valid), 0);
      for (int k = 1; k <= 5; k++) begin
         push(8'h10 + 8'(k), 1'b0);
         chk("R6 count step", 32'(xfer_cnt), 32'(5 - k));
         if (k == 2) begin
            repeat (3) @(negedge clk);
            chk("R6 stall holds", 32'(xfer_cnt), 32'd3);
            chk("R5 no early tc", 32'(tc_flag), 0);
         end
      end
      chk("R5 tc", 32'(tc_flag), 1);
      chk("R5 idle", 32'(busy), 0);
   endtask

   task automatic t_outbound();
      set_cnt(8'd5, 8'd0, 8'd0);
      issue(1'b1, 1'b0);
      chk("R12 in_ready low", 32'(in_ready), 0);
      for (int k = 1; k <= 5; k++) pull("R8 readback", 8'h10 + 8'(k));
      chk("R5 out tc", 32'(tc_flag), 1);
      chk("R5 out cnt", 32'(xfer_cnt), 0);
   endtask

   task automatic t_nondma();
      set_cnt(8'd9, 8'd0, 8'd0);
      issue(1'b0, 1'b1);
      chk("R10 busy", 32'(busy), 0);
      chk("R10 tc kept", 32'(tc_flag), 1);
      chk("R10 cnt kept", 32'(xfer_cnt), 0);
      chk("R10 in_ready", 32'(in_ready), 0);
   endtask

   task automatic t_wrap();
      set_addr(32'h0000_0000);
      set_cnt(8'd3, 8'd0, 8'd0);
      issue(1'b1, 1'b1);
      push(8'hA1, 1'b0); push(8'hB2, 1'b0); push(8'hC3, 1'b0);
      set_addr(32'(WIN - 2));
      set_cnt(8'd2, 8'd0, 8'd0);
      issue(1'b1, 1'b1);
      push(8'hE1, 1'b0); push(8'hF2, 1'b0);
      set_addr(32'hFFFF_0000 | 32'(WIN - 2));
      set_cnt(8'd5, 8'd0, 8'd0);
      issue(1'b1, 1'b0);
      pull("R8 wrap", 8'hE1); pull("R8 wrap", 8'hF2);
      pull("R8 wrap", 8'hA1); pull("R8 wrap", 8'hB2); pull("R8 wrap", 8'hC3);
      chk("R8 wrap done", 32'(tc_flag), 1);
   endtask

   task automatic t_clip();
      int n = 0;
      set_addr(32'(WIN - 3));
      set_cnt(8'd10, 8'd0, 8'd0);
      issue(1'b1, 1'b1);
      in_valid = 1'b1;
      while (busy && n < 20) begin @(negedge clk); n++; end
      in_valid = 1'b0;
      chk("R9 clipped beats", 32'(n), 32'd3);
      chk("R9 tc", 32'(tc_flag), 1);
      chk("R9 cnt", 32'(xfer_cnt), 0);
      n = 0;
      set_addr(32'h0);
      set_cnt(8'd0, 8'd0, 8'd0);
      issue(1'b1, 1'b1);
      in_valid = 1'b1;
      while (busy && n < 70000) begin @(negedge clk); n++; end
      in_valid = 1'b0;
      chk("R9 zero count clipped to window", 32'(n), 32'(WIN));
   endtask

   task automatic t_length();
      int n = 0;
      set_addr(32'h0);
      set_cnt(8'd0, 8'd0, 8'd0);
      issue(1'b1, 1'b0);
      out_ready = 1'b1;
      while (busy && n < 70000) begin @(negedge clk); n++; end
      out_ready = 1'b0;
      chk("R3 zero means 65536", 32'(n), 32'd65536);
      chk("R3 tc after 65536", 32'(tc_flag), 1);
      n = 0;
      set_cnt(8'd2, 8'd1, 8'd0);
      issue(1'b1, 1'b0);
      out_ready = 1'b1;
      while (busy && n < 70000) begin @(negedge clk); n++; end
      out_ready = 1'b0;
      chk("R3 low+256*mid", 32'(n), 32'd258);
   endtask

   task automatic t_residual();
      set_addr(32'h40);
      set_cnt(8'd8, 8'd0, 8'd0);
      issue(1'b1, 1'b1);
      push(8'h01, 1'b0); push(8'h02, 1'b0);
      set_cnt(8'd50, 8'd0, 8'd0);
      issue(1'b1, 1'b0);
      chk("R11 no reload", 32'(xfer_cnt), 32'd6);
      chk("R11 still busy", 32'(busy), 1);
      chk("R11 direction kept", 32'(in_ready), 1);
      push(8'h03, 1'b1);
      chk("R7 idle", 32'(busy), 0);
      chk("R7 no tc", 32'(tc_flag), 0);
      chk("R7 residual", 32'(xfer_cnt), 32'd5);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_addr();
      t_inbound();
      t_outbound();
      t_nondma();
      t_wrap();
      t_clip();
      t_length();
      t_residual();
      summary();
   end

endmodule